// File: doc/BRIEF.md
# Fractional-Ratio Audio Frame Clock Generator

This block derives the oversampling tick, the frame clock and a bit-clock enable for an audio serial port from the prescaled master clock. It uses a rational ratio NI/MI. Each master-clock cycle adds NI to a phase accumulator. When the sum reaches MI, the block subtracts MI and issues one oversampling tick. A frame lasts 64 or 128 ticks. The frame clock is low for the first half of the frame (left channel) and high for the second half.

The ratio comes from one of three sources, taken in fixed priority. The first is a quick-configuration table of four fixed ratios. The second is a table of exact-integer presets, selected by a 4-bit frequency code. The third is the manually programmed NI and MI values. The manual values stay on the inputs while a higher-priority source overrides them, and they take effect again when that source is released.

A new ratio or oversampling rate is adopted only at a frame boundary, so no frame is ever cut short. In slave operation the block stops generating clocks and releases the frame clock.

Top module: `audio_frame_clkgen`

## Requirements
- R1: When `quick_en` is 1, the ratio comes from the quick table, regardless of the frequency code and manual inputs. The table is indexed by `quick_sel`: 0 gives 64/125, 1 gives 294/625, 2 gives 128/375 and 3 gives 64/375.
- R2: When `quick_en` is 0 and `freq_code[3]` is 1, the code `freq_code[2:0]` picks an exact preset: 0 gives 1/2, 1 gives 1/4, 2 gives 1/3, 3 gives 1/6, 4 gives 1/8 and 5 gives 147/320. Codes 6 and 7, and any code with `freq_code[3]` = 0, select the manual ratio.
- R3: While a fixed source is active, changes to the manual inputs have no effect on the output. When the fixed source is released, the manual values then present take effect.
- R4: With `use_mi` = 0, the manual MI is 0xFFFF and `mi_val` has no effect. With `use_mi` = 1, MI equals `mi_val`. The manual NI is {`ni_upper`, `ni_lower`}.
- R5: `osr_tick` pulses for one cycle whenever the accumulator plus NI reaches MI. The remainder is kept, so over MI cycles exactly NI ticks occur when NI ≤ MI.
- R6: `osr_64` = 1 gives 64 ticks per frame and 0 gives 128 ticks per frame. `frame_start` pulses for one cycle at the start of each frame. `lrclk` is low for the first half of the frame's ticks and high for the second half. `lrclk`, `frame_start` and `bclk_en` change one cycle after the tick that causes them.
- R7: `bclk_en` pulses 64 times per frame: on every tick at 64x oversampling, and on every second tick at 128x. One of these pulses coincides with `frame_start`.
- R8: A change of ratio source, ratio or oversampling rate takes effect only at the next frame boundary. The frame in progress completes with its old length. At that boundary the accumulator restarts from zero.
- R9: While `slave_mode` is 1, the block produces no ticks, frame starts or bit-clock enables. `lrclk_oe` goes low one cycle after entry and `lrclk` is held low. Ratio inputs have no effect. After release, the block behaves as it does after reset.
- R10: During reset all outputs are low. After reset release (or slave release), the first `frame_start` arrives one cycle after the first tick. For a 1/2 ratio, that is the third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaled master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | 1 = external frame clock; block idles |
| quick_en | input | 1 | Quick-configuration source enable |
| quick_sel | input | 2 | Quick table index |
| freq_code | input | 4 | Exact-preset code; bit 3 enables |
| ni_upper | input | 7 | Manual NI bits 14..8 |
| ni_lower | input | 8 | Manual NI bits 7..0 |
| mi_val | input | 16 | Manual MI |
| use_mi | input | 1 | 1 = use `mi_val`, 0 = MI forced to 0xFFFF |
| osr_64 | input | 1 | 1 = 64x oversampling, 0 = 128x |
| osr_tick | output | 1 | One-cycle oversampling tick |
| lrclk | output | 1 | Frame clock, low = left |
| lrclk_oe | output | 1 | Frame clock drive enable |
| frame_start | output | 1 | One-cycle strobe at left-channel start |
| bclk_en | output | 1 | Bit-clock enable, 64 per frame |

## Verification
The tick that closes a frame and a pending ratio change can land in the same cycle. In that cycle the accumulator must restart with the new NI while the counter wraps. The bench provokes this by rewriting the ratio ten cycles into a frame. It then judges both sides of the boundary: the interrupted frame must keep its old length and the following frame must have exactly the new length. A second coincidence, entering slave operation while a frame is running, is judged by the immediate silence of tick, strobe and bit-clock enable. After release, the first strobe must arrive on the third cycle.

// File: rtl/afc_pkg.sv
package afc_pkg;
    localparam int NI_W     = 15;
    localparam int NI_LO_W  = 8;
    localparam int NI_UP_W  = NI_W - NI_LO_W;
    localparam int MI_W     = 16;
    localparam int ACC_W    = MI_W + 1;
    localparam int OSR_HI   = 128;
    localparam int OSR_LO   = 64;
    localparam int CNT_W    = $clog2(OSR_HI);

    typedef struct packed {
        logic [NI_W-1:0] ni;
        logic [MI_W-1:0] mi;
        logic            osr64;
    } ratio_t;

    typedef struct packed {
        logic            hit;
        logic [NI_W-1:0] ni;
        logic [MI_W-1:0] mi;
    } preset_t;

    function automatic preset_t exact_lookup(input logic [2:0] code);
        preset_t p;
        p.hit = 1'b1;
        case (code)
            3'd0:    begin p.ni = NI_W'(1);   p.mi = MI_W'(2);   end
            3'd1:    begin p.ni = NI_W'(1);   p.mi = MI_W'(4);   end
            3'd2:    begin p.ni = NI_W'(1);   p.mi = MI_W'(3);   end
            3'd3:    begin p.ni = NI_W'(1);   p.mi = MI_W'(6);   end
            3'd4:    begin p.ni = NI_W'(1);   p.mi = MI_W'(8);   end
            3'd5:    begin p.ni = NI_W'(147); p.mi = MI_W'(320); end
            default: begin p.hit = 1'b0; p.ni = '0; p.mi = '1;   end
        endcase
        return p;
    endfunction

    function automatic preset_t quick_lookup(input logic [1:0] code);
        preset_t p;
        p.hit = 1'b1;
        case (code)
            2'd0:    begin p.ni = NI_W'(64);  p.mi = MI_W'(125); end
            2'd1:    begin p.ni = NI_W'(294); p.mi = MI_W'(625); end
            2'd2:    begin p.ni = NI_W'(128); p.mi = MI_W'(375); end
            default: begin p.ni = NI_W'(64);  p.mi = MI_W'(375); end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/afc_ratio_select.sv
module afc_ratio_select
    import afc_pkg::*;
(
    input  logic               quick_en,
    input  logic [1:0]         quick_sel,
    input  logic [3:0]         freq_code,
    input  logic [NI_UP_W-1:0] ni_upper,
    input  logic [NI_LO_W-1:0] ni_lower,
    input  logic [MI_W-1:0]    mi_val,
    input  logic               use_mi,
    input  logic               osr_64,
    output ratio_t             sel_o
);
    preset_t q_p;
    preset_t x_p;

    always_comb begin
        q_p = quick_lookup(quick_sel);
        x_p = exact_lookup(freq_code[2:0]);
        sel_o.osr64 = osr_64;
        if (quick_en) begin
            sel_o.ni = q_p.ni;
            sel_o.mi = q_p.mi;
        end else if (freq_code[3] && x_p.hit) begin
            sel_o.ni = x_p.ni;
            sel_o.mi = x_p.mi;
        end else begin
            sel_o.ni = {ni_upper, ni_lower};
            sel_o.mi = use_mi ? mi_val : {MI_W{1'b1}};
        end
    end
endmodule

// File: rtl/afc_phase_acc.sv
module afc_phase_acc
    import afc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            clear_i,
    input  logic [NI_W-1:0] ni_i,
    input  logic [MI_W-1:0] mi_i,
    output logic            tick_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        base = clear_i ? '0 : st_q.acc;
        sum  = base + ACC_W'(ni_i);
        if (!run_i) begin
            st_d.acc  = '0;
            st_d.tick = 1'b0;
        end else if (sum >= ACC_W'(mi_i)) begin
            st_d.acc  = sum - ACC_W'(mi_i);
            st_d.tick = 1'b1;
        end else begin
            st_d.acc  = sum;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    assert_no_tick_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !tick_o);
    assert_rem_below_mi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(run_i) && $past(ni_i) <= $past(mi_i)) |-> st_q.acc < ACC_W'($past(mi_i)));
endmodule

// File: rtl/afc_frame_counter.sv
module afc_frame_counter
    import afc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic osr64_i,
    output logic boundary_o,
    output logic lrclk_o,
    output logic frame_start_o,
    output logic bclk_en_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lr;
        logic             fs;
        logic             bclk;
    } fc_st_t;

    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(OSR_HI - 1);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(OSR_LO - 1);
    localparam logic [CNT_W-1:0] IDLE    = {CNT_W{1'b1}};

    fc_st_t st_d, st_q;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] half_idx;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        last_idx   = osr64_i ? LAST_LO : LAST_HI;
        half_idx   = osr64_i ? CNT_W'(OSR_LO / 2) : CNT_W'(OSR_HI / 2);
        boundary_o = run_i && tick_i && (st_q.cnt >= last_idx);
        nxt        = boundary_o ? '0 : st_q.cnt + 1'b1;
        st_d       = st_q;
        st_d.fs    = 1'b0;
        st_d.bclk  = 1'b0;
        if (!run_i) begin
            st_d.cnt = IDLE;
            st_d.lr  = 1'b0;
        end else if (tick_i) begin
            st_d.cnt  = nxt;
            st_d.lr   = (nxt >= half_idx);
            st_d.fs   = boundary_o;
            st_d.bclk = osr64_i || !nxt[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: IDLE, lr: 1'b0, fs: 1'b0, bclk: 1'b0};
        else        st_q <= st_d;
    end

    assign lrclk_o       = st_q.lr;
    assign frame_start_o = st_q.fs;
    assign bclk_en_o     = st_q.bclk;

    assert_left_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> !lrclk_o);
    assert_lr_moves_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lrclk_o) && $past(run_i)) |-> $past(tick_i));
    assert_bclk_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> bclk_en_o);
endmodule

// File: rtl/audio_frame_clkgen.sv
module audio_frame_clkgen
    import afc_pkg::*;
(
    input  logic        pclk,
    input  logic        rst_n,
    input  logic        slave_mode,
    input  logic        quick_en,
    input  logic [1:0]  quick_sel,
    input  logic [3:0]  freq_code,
    input  logic [6:0]  ni_upper,
    input  logic [7:0]  ni_lower,
    input  logic [15:0] mi_val,
    input  logic        use_mi,
    input  logic        osr_64,
    output logic        osr_tick,
    output logic        lrclk,
    output logic        lrclk_oe,
    output logic        frame_start,
    output logic        bclk_en
);
    typedef struct packed {
        ratio_t act;
        logic   run;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    ratio_t  sel;
    ratio_t  eff;
    logic    load;
    logic    boundary;
    logic    tick;

    afc_ratio_select u_sel (
        .quick_en (quick_en),
        .quick_sel(quick_sel),
        .freq_code(freq_code),
        .ni_upper (ni_upper),
        .ni_lower (ni_lower),
        .mi_val   (mi_val),
        .use_mi   (use_mi),
        .osr_64   (osr_64),
        .sel_o    (sel)
    );

    always_comb begin
        load = !slave_mode && (!st_q.run || (boundary && (sel != st_q.act)));
        eff  = load ? sel : st_q.act;
        st_d = st_q;
        if (slave_mode) begin
            st_d.run = 1'b0;
        end else if (load) begin
            st_d.act = sel;
            st_d.run = 1'b1;
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    afc_phase_acc u_acc (
        .clk    (pclk),
        .rst_n  (rst_n),
        .run_i  (!slave_mode),
        .clear_i(load),
        .ni_i   (eff.ni),
        .mi_i   (eff.mi),
        .tick_o (tick)
    );

    afc_frame_counter u_frm (
        .clk          (pclk),
        .rst_n        (rst_n),
        .run_i        (st_q.run && !slave_mode),
        .tick_i       (tick),
        .osr64_i      (st_q.act.osr64),
        .boundary_o   (boundary),
        .lrclk_o      (lrclk),
        .frame_start_o(frame_start),
        .bclk_en_o    (bclk_en)
    );

    assign osr_tick = tick;
    assign lrclk_oe = st_q.run;

    assert_ratio_at_boundary_R8: assert property (@(posedge pclk) disable iff (!rst_n)
        ($past(st_q.run) && !$stable(st_q.act)) |-> $past(boundary));
    assert_release_in_slave_R9: assert property (@(posedge pclk) disable iff (!rst_n)
        slave_mode |=> !lrclk_oe);
endmodule

// File: tb/audio_frame_clkgen_tb_top.sv
module audio_frame_clkgen_tb_top;
    logic        pclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slave_mode = 1'b0;
    logic        quick_en = 1'b0;
    logic [1:0]  quick_sel = 2'd0;
    logic [3:0]  freq_code = 4'd0;
    logic [6:0]  ni_upper = 7'd0;
    logic [7:0]  ni_lower = 8'd1;
    logic [15:0] mi_val = 16'd2;
    logic        use_mi = 1'b1;
    logic        osr_64 = 1'b1;
    logic        osr_tick, lrclk, lrclk_oe, frame_start, bclk_en;

    int checks = 0;
    int errors = 0;

    always #10 pclk = ~pclk;

    audio_frame_clkgen dut_i (
        .pclk(pclk), .rst_n(rst_n), .slave_mode(slave_mode),
        .quick_en(quick_en), .quick_sel(quick_sel), .freq_code(freq_code),
        .ni_upper(ni_upper), .ni_lower(ni_lower), .mi_val(mi_val),
        .use_mi(use_mi), .osr_64(osr_64),
        .osr_tick(osr_tick), .lrclk(lrclk), .lrclk_oe(lrclk_oe),
        .frame_start(frame_start), .bclk_en(bclk_en)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic manual(input int ni, input int mi, input logic um, input logic o64);
        @(negedge pclk);
        quick_en = 1'b0; freq_code = 4'd0;
        ni_upper = 7'(ni >> 8); ni_lower = 8'(ni); mi_val = 16'(mi);
        use_mi = um; osr_64 = o64;
    endtask

    task automatic wait_fs(output int n);
        n = 0;
        do begin
            @(negedge pclk);
            n++;
        end while (!frame_start && n < 6000);
        if (n >= 6000) n = -1;
    endtask

    task automatic measure(output int len, output int hi, output int bc);
        len = 0; hi = 0; bc = 0;
        do begin
            if (lrclk) hi++;
            if (bclk_en) bc++;
            len++;
            @(negedge pclk);
        end while (!frame_start && len < 6000);
    endtask

    task automatic frame_len(input string tag, input int exp);
        int n, len, hi, bc;
        wait_fs(n);
        measure(len, hi, bc);
        check(tag, len, exp);
    endtask

    task automatic t_reset_R10();
        int n;
        repeat (4) @(negedge pclk);
        check("R10 reset outputs", {osr_tick, lrclk, lrclk_oe, frame_start, bclk_en}, 0);
        rst_n = 1'b1;
        wait_fs(n);
        check("R10 first frame_start cycle", n, 3);
    endtask

    task automatic t_frame_R6_R7();
        int len, hi, bc;
        measure(len, hi, bc);
        check("R6 frame length osr64", len, 128);
        check("R6 lrclk high cycles osr64", hi, 64);
        check("R7 bclk pulses osr64", bc, 64);
        @(negedge pclk); osr_64 = 1'b0;
        wait_fs(len);
        measure(len, hi, bc);
        check("R6 frame length osr128", len, 256);
        check("R6 lrclk high cycles osr128", hi, 128);
        check("R7 bclk pulses osr128", bc, 64);
    endtask

    task automatic t_accum_R5();
        int n, t;
        manual(3, 7, 1'b1, 1'b1);
        wait_fs(n);
        t = 0;
        repeat (700) begin
            if (osr_tick) t++;
            @(negedge pclk);
        end
        check("R5 ticks in 700 cycles at 3/7", t, 300);
    endtask

    task automatic t_mi_R4();
        manual(16'h5555, 4, 1'b0, 1'b1);
        frame_len("R4 use_mi=0 forces MI", 192);
        manual(1, 4, 1'b1, 1'b1);
        frame_len("R4 use_mi=1 takes mi_val", 256);
    endtask

    task automatic t_exact_R2();
        manual(1, 4, 1'b1, 1'b0);
        @(negedge pclk); freq_code = 4'b1000;
        frame_len("R2 preset 0 osr128", 256);
        @(negedge pclk); freq_code = 4'b1100; osr_64 = 1'b1;
        frame_len("R2 preset 4 osr64", 512);
        @(negedge pclk); freq_code = 4'b1110;
        frame_len("R2 code 6 falls back to manual", 256);
        @(negedge pclk); freq_code = 4'b0011;
        frame_len("R2 bit3 clear uses manual", 256);
    endtask

    task automatic t_keep_R3();
        manual(1, 4, 1'b1, 1'b1);
        @(negedge pclk); freq_code = 4'b1000;
        frame_len("R3 exact overrides manual", 128);
        @(negedge pclk); mi_val = 16'd8;
        frame_len("R3 manual change ignored while exact", 128);
        @(negedge pclk); freq_code = 4'b0000;
        frame_len("R3 manual resumes after exact off", 512);
    endtask

    task automatic t_prio_R1();
        manual(1, 2, 1'b1, 1'b1);
        @(negedge pclk); freq_code = 4'b1000; quick_en = 1'b1; quick_sel = 2'd3;
        frame_len("R1 quick wins over exact", 375);
        @(negedge pclk); quick_sel = 2'd0;
        frame_len("R1 quick entry 0", 125);
        @(negedge pclk); quick_en = 1'b0;
        frame_len("R1 exact after quick off", 128);
    endtask

    task automatic t_boundary_R8();
        int n, len, hi, bc;
        manual(1, 2, 1'b1, 1'b1);
        wait_fs(n);
        wait_fs(n);
        repeat (10) @(negedge pclk);
        ni_lower = 8'd1; mi_val = 16'd4;
        wait_fs(n);
        check("R8 interrupted frame keeps old length", n + 10, 128);
        measure(len, hi, bc);
        check("R8 next frame has new length", len, 256);
    endtask

    task automatic t_slave_R9();
        int n, act;
        manual(1, 2, 1'b1, 1'b1);
        wait_fs(n);
        repeat (20) @(negedge pclk);
        slave_mode = 1'b1;
        @(negedge pclk);
        act = 0;
        repeat (400) begin
            if (osr_tick || frame_start || bclk_en || lrclk || lrclk_oe) act++;
            @(negedge pclk);
            mi_val = 16'd3;
        end
        check("R9 outputs quiet in slave", act, 0);
        mi_val = 16'd2;
        slave_mode = 1'b0;
        wait_fs(n);
        check("R9 first frame_start after slave release", n, 3);
        check("R9 lrclk_oe back on", lrclk_oe, 1);
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_R10();
        t_frame_R6_R7();
        t_accum_R5();
        t_mi_R4();
        t_exact_R2();
        t_keep_R3();
        t_prio_R1();
        t_boundary_R8();
        t_slave_R9();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule